// File: doc/BRIEF.md
# Programmable countdown event timer

A single countdown timer driven by an external tick strobe and programmed through two word registers: a control register and a timeout register. Software sets the run enable in the control register, then writes a timeout; that write loads the counter and starts the countdown at once. Each tick decrements the counter. A tick that finds the counter at zero ends the countdown and, if interrupts are enabled, latches a pending flag that drives the interrupt line until software clears it.

The run enable is the master gate for the whole timer. While it is clear the counter is frozen, timeout writes are discarded, and the pending flag cannot be cleared. A clear must therefore be written together with the run enable, in the same control write. Writing zero to the control register freezes the timer and masks its interrupt.

Top module: `countdown_timer`

## Requirements
- R1: After reset the control register and the timeout register both read zero, and irq is low.
- R2: A write to the timeout register (offset 0x44) while the run enable is set loads the counter with the written value and starts the countdown. This also applies when a countdown is already in progress. Reading offset 0x44 returns the current count.
- R3: A write to the timeout register while the run enable is clear is ignored, and the count reads back unchanged.
- R4: A cycle with tick high, the run enable set and a countdown in progress decrements the count by one. Without a tick, or with the run enable clear, the count holds.
- R5: A tick that finds the count at zero ends the countdown. After a load of N, the pending flag is therefore set by the (N+1)th tick. Later ticks leave the count at zero and do not restart the countdown.
- R6: A control write (offset 0x40) with bit 4 set and bit 0 clear does not clear the pending flag.
- R7: A control write with bit 4 and bit 0 both set clears the pending flag. An expiry in the same cycle takes priority over the clear.
- R8: In the control register, bit 0 is the run enable and bit 1 is the interrupt enable; both read back as written. Bit 4 is a clear strobe and reads as zero, and all other bits read zero.
- R9: irq is high exactly when the pending flag and the interrupt enable are both set. The pending flag is set only when the interrupt enable is set at the moment of expiry.
- R10: Loading a timeout of zero sets the pending flag on the first tick after the load.
- R11: Writing zero to the control register stops counting and holds irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (8) | Register byte offset for reads and writes |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for addr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
Random timeouts from 0 to 15 are loaded and then ticked with random idle cycles between ticks. This separates counting on tick strobes from counting on clock cycles, and it checks the expiry on the (N+1)th tick against a bench function. Directed cases cover operations with the run enable clear: timeout writes, clears and held counts. These separate gating by the run enable from plain masking of the interrupt. Further directed cases cover a zero timeout, a reload during a countdown, an expiry with the interrupt enable clear, and the clear strobe reading as zero.

// File: rtl/countdown_timer.sv
module countdown_timer #(
  parameter int AW       = 8,
  parameter int DW       = 32,
  parameter int CNT_W    = 32,
  parameter logic [AW-1:0] CTRL_OFS = 8'h40,
  parameter logic [AW-1:0] VAL_OFS  = 8'h44
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam int EN_B  = 0;
  localparam int IE_B  = 1;
  localparam int CLR_B = 4;

  logic             en_q, ie_q, pend_q, run_q;
  logic [CNT_W-1:0] cnt_q;

  wire ctrl_wr = wr_en && (addr == CTRL_OFS);
  wire load    = wr_en && (addr == VAL_OFS) && en_q;
  wire step    = tick && en_q && run_q && !load;
  wire expire  = step && (cnt_q == '0);
  wire clr     = ctrl_wr && wdata[EN_B] && wdata[CLR_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q <= wdata[EN_B];
        ie_q <= wdata[IE_B];
      end
      if (load) begin
        cnt_q <= wdata[CNT_W-1:0];
        run_q <= 1'b1;
      end else if (expire) begin
        run_q <= 1'b0;
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
      if (expire && ie_q)
        pend_q <= 1'b1;
      else if (clr)
        pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_OFS) begin
      rdata[EN_B] = en_q;
      rdata[IE_B] = ie_q;
    end else if (addr == VAL_OFS) begin
      rdata[CNT_W-1:0] = cnt_q;
    end
  end

  assign irq = pend_q && ie_q;
endmodule

// File: rtl/countdown_timer_chk.sv
module countdown_timer_chk #(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int CNT_W = 32,
  parameter logic [AW-1:0] CTRL_OFS = 8'h40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    wdata,
  input logic             irq,
  input logic             en_q,
  input logic             ie_q,
  input logic             pend_q,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_q
);
  wire clr_try = wr_en && (addr == CTRL_OFS) && wdata[0];

  assert_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(cnt_q));

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_try) |=> pend_q);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);

  assert_pend_needs_ie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !ie_q) |=> !pend_q);

  assert_stop_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en_q && run_q && cnt_q == '0 && !wr_en) |=> !run_q);

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> ($stable(cnt_q) && !run_q));
endmodule

bind countdown_timer countdown_timer_chk #(.AW(AW), .DW(DW), .CNT_W(CNT_W), .CTRL_OFS(CTRL_OFS)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq(irq), .en_q(en_q), .ie_q(ie_q), .pend_q(pend_q),
  .run_q(run_q), .cnt_q(cnt_q)
);

// File: tb/test_countdown_timer.sv
module test_countdown_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  localparam logic [7:0] CTRL = 8'h40;
  localparam logic [7:0] VAL  = 8'h44;

  countdown_timer i_countdown_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic bit exp_fired(int n, int ticks);
    return ticks >= n + 1;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(bit t);
    @(negedge clk);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(CTRL, v); check("R1 ctrl", v, 0);
    rd(VAL, v);  check("R1 value", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    wr(VAL, 32'd9);
    rd(VAL, v); check("R3 ignored load", v, 0);

    wr(CTRL, 32'h13);
    rd(CTRL, v); check("R8 readback", v, 32'h3);
    wr(VAL, 32'd5);
    rd(VAL, v); check("R2 load", v, 5);
    cyc(0); cyc(0);
    rd(VAL, v); check("R4 no tick", v, 5);
    cyc(1); cyc(1); cyc(1);
    rd(VAL, v); check("R4 decrement", v, 2);
    wr(VAL, 32'd4);
    rd(VAL, v); check("R2 reload", v, 4);
    for (int i = 0; i < 4; i++) cyc(1);
    rd(VAL, v); check("R5 at zero", v, 0);
    check("R5 not yet", {31'b0, irq}, 0);
    cyc(1);
    check("R5 fired", {31'b0, irq}, 1);
    cyc(1); cyc(1);
    rd(VAL, v); check("R5 stopped", v, 0);

    wr(CTRL, 32'h12);
    check("R6 clear without enable", {31'b0, irq}, 1);
    cyc(1);
    wr(CTRL, 32'h13);
    check("R7 clear", {31'b0, irq}, 0);

    wr(CTRL, 32'h1);
    wr(VAL, 32'd1);
    cyc(1); cyc(1);
    wr(CTRL, 32'h3);
    check("R9 no pend when ie clear", {31'b0, irq}, 0);

    wr(VAL, 32'd0);
    check("R10 before tick", {31'b0, irq}, 0);
    cyc(1);
    check("R10 zero load", {31'b0, irq}, 1);
    wr(CTRL, 32'h0);
    check("R9 masked", {31'b0, irq}, 0);
    wr(CTRL, 32'h13);

    wr(VAL, 32'd10);
    wr(CTRL, 32'h0);
    cyc(1); cyc(1); cyc(1);
    rd(VAL, v); check("R11 frozen", v, 10);
    check("R11 irq low", {31'b0, irq}, 0);

    for (int k = 0; k < 40; k++) begin
      int n, ticks;
      bit ok;
      n = int'($urandom % 16);
      wr(CTRL, 32'h13);
      wr(VAL, n);
      ticks = 0;
      ok = 1;
      while (ticks < n + 3) begin
        bit t;
        t = 1'($urandom % 2);
        cyc(t);
        ticks += int'(t);
        if (irq !== exp_fired(n, ticks)) ok = 0;
      end
      check("R5 random expiry", {31'b0, ok}, 1);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule